// File: doc/BRIEF.md
# Three-Rail Power Sequencer

This block brings up three supply rails in a fixed order and takes them down in the opposite order. Each rail is represented by an open-drain control: the block asks the pad driver either to pull the line low (rail held off) or to let go of it (rail released, pulled high outside the chip). When the enable input goes high, rail 1 is released after one sequencing interval, rail 2 one interval later and rail 3 one interval after that. When the enable goes low, rail 3 is held off first, then rail 2, then rail 1, with the same spacing.

The interval is timed from a free-running oscillator clock. A prescaler divides that clock into a slow tick, and a step counter counts a set number of ticks. By default the oscillator is 500 kHz, the prescale ratio is 24 and the interval is 60 ms, which is 1250 ticks. The enable input passes through a two-flop synchronizer. It is then gated by an internal power-on qualifier, which stays low until reset has been released and synchronized. If the enable changes while a sequence is running, the sequencer turns around from the rail it has reached.

A 3-bit status word reports the qualified enable and the number of rails that are released.

Top module: `rail_sequencer`

## Requirements
- R1: While rst_n is low, all three bits of rail_hold_low are 1 (every rail driven low) and seq_status is 0. This takes effect as soon as rst_n falls, without waiting for a clock edge.
- R2: While reset is active, en_in has no effect. If en_in is already high when rst_n is released, rail 1 is released exactly N+5 rising edges after the release. N is the interval in clocks.
- R3: The interval is N = PRESCALE*STEP_TICKS clocks, where STEP_TICKS = OSC_HZ*STEP_MS/(PRESCALE*1000). In a running idle block, rail 1 is released exactly N+3 edges after en_in rises: two edges of synchronizer, one edge to restart the timer, then N.
- R4: Power-up releases the rails in a fixed order, with N edges between releases. Bit 0 of rail_hold_low (rail 1) goes to 0 first, then bit 1, then bit 2.
- R5: Power-down holds the rails off in reverse order. Bit 2 returns to 1 exactly N+3 edges after en_in falls, then bit 1 after N more edges, then bit 0 after N more edges.
- R6: At most one bit of rail_hold_low changes per clock. The vector is always one of 111, 110, 100 or 000.
- R7: If en_in falls during power-up, the sequencer starts powering down from the highest rail already released. That rail is held off N+3 edges after the fall.
- R8: If en_in rises during power-down, the sequencer resumes power-up from its current state. The next rail is released N+3 edges after the rise.
- R9: seq_status bit 2 is the qualified enable. Bits 1:0 are the number of released rails (0 to 3).
- R10: While en_in stays steady with all rails released, or with all rails held off, rail_hold_low does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_in | input | 1 | Asynchronous sequencing enable |
| rail_hold_low | output | 3 | Per-rail drive-low enable for the open-drain pads; bit i is rail i+1 |
| seq_status | output | 3 | {qualified enable, count of released rails} |

## Verification
A corrupted level register shows up at the pad enables at the very next edge. It appears either as a pattern that is not a thermometer code or as a two-rail jump, and the per-cycle monitor catches both. A prescaler or step counter that is off by even one count moves a release by one or more edges. Because every transition is sampled on both sides of its exact expected edge, such a shift shows within one interval. A direction flag that misses a reversal leaves the rails moving the wrong way, which is visible at most N+3 edges after the enable changes.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_RAILS = 3;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2,
    LVL_ALL  = 2'd3
  } level_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_in};
  end

  assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/seq_prescaler.sv
module seq_prescaler #(
  parameter int PRESCALE = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (PRESCALE > 1) begin : g_chk
      AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick); // R3
    end
  endgenerate
endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int STEP_TICKS = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(STEP_TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = tick && (cnt_q == LAST);
  assign cnt_en = restart || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || done) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (STEP_TICKS > 1) begin : g_chk
      AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done); // R3
    end
  endgenerate
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enr,
  input  logic   step_done,
  output logic   restart,
  output level_e level
);
  level_e level_q, level_d;
  logic   dir_q;
  logic   turn, can_move, advance;

  assign turn     = (enr != dir_q);
  assign can_move = enr ? (level_q != LVL_ALL) : (level_q != LVL_NONE);
  assign advance  = step_done && !turn && can_move;
  assign restart  = turn || advance;
  assign level    = level_q;

  always_comb begin
    level_d = level_q;
    if (advance) begin
      if (enr) level_d = level_e'(level_q + 2'd1);
      else     level_d = level_e'(level_q - 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_NONE;
      dir_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      dir_q   <= enr;
    end
  end

  AST_UP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q > $past(level_q)) |-> $past(enr)); // R4
  AST_DOWN_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q < $past(level_q)) |-> !$past(enr)); // R5
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import seq_pkg::*;
#(
  parameter int OSC_HZ   = 500000,
  parameter int PRESCALE = 24,
  parameter int STEP_MS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  output logic [2:0] rail_hold_low,
  output logic [2:0] seq_status
);
  localparam int STEP_TICKS = (OSC_HZ * STEP_MS) / (PRESCALE * 1000);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       por_ok;
  logic       en_sync;
  logic       enr;
  logic       tick, done, restart;
  level_e     level;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) por_ok <= 1'b0;
    else          por_ok <= 1'b1;
  end

  seq_sync #(.STAGES(2)) u_en_sync (
    .clk(clk), .rst_n(rst_i_n), .d_in(en_in), .q_out(en_sync)
  );

  assign enr = en_sync && por_ok;

  seq_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .tick(tick)
  );

  seq_step_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .tick(tick), .done(done)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .enr(enr), .step_done(done),
    .restart(restart), .level(level)
  );

  generate
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      assign rail_hold_low[i] = !(level > level_e'(i));
    end
  endgenerate

  assign seq_status = {enr, level};

  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !por_ok |-> (rail_hold_low == 3'b111)); // R2
  AST_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(rail_hold_low ^ $past(rail_hold_low)) <= 1); // R6
  AST_RELEASE_NEEDS_ENR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|($past(rail_hold_low) & ~rail_hold_low)) |-> $past(enr)); // R4
  AST_HOLD_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|(~$past(rail_hold_low) & rail_hold_low)) |-> !$past(enr)); // R5
endmodule

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
  logic       clk;
  logic       rst_n;
  logic       en_in;
  logic [2:0] rail_hold_low;
  logic [2:0] seq_status;

  int errors = 0;
  int checks = 0;
  int mon_bad = 0;
  logic [2:0] prev_hold;

  // N = PRESCALE * STEP_TICKS = 4 * (1000*20/(4*1000)) = 20 clocks
  rail_sequencer #(.OSC_HZ(1000), .PRESCALE(4), .STEP_MS(20)) uut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in),
    .rail_hold_low(rail_hold_low), .seq_status(seq_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {en (1), negedges to wait (8), expected rail_hold_low (3)}
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 8'd22, 3'b110}, {1'b0, 8'd1,  3'b111}, {1'b0, 8'd10, 3'b111},
    {1'b1, 8'd22, 3'b111}, {1'b1, 8'd1,  3'b110}, {1'b1, 8'd19, 3'b110},
    {1'b1, 8'd1,  3'b100}, {1'b1, 8'd19, 3'b100}, {1'b1, 8'd1,  3'b000},
    {1'b1, 8'd40, 3'b000}, {1'b0, 8'd22, 3'b000}, {1'b0, 8'd1,  3'b100},
    {1'b0, 8'd19, 3'b100}, {1'b0, 8'd1,  3'b110}, {1'b0, 8'd19, 3'b110},
    {1'b0, 8'd1,  3'b111}, {1'b0, 8'd30, 3'b111}, {1'b1, 8'd63, 3'b000},
    {1'b0, 8'd23, 3'b100}, {1'b1, 8'd22, 3'b100}, {1'b1, 8'd1,  3'b000},
    {1'b0, 8'd63, 3'b111}
  };

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int idx);
    if (idx < 2)  return "R7";
    if (idx < 3)  return "R10";
    if (idx < 9)  return "R4";
    if (idx < 10) return "R10";
    if (idx < 16) return "R5";
    if (idx < 17) return "R10";
    if (idx < 18) return "R4";
    if (idx < 21) return "R8";
    return "R5";
  endfunction

  // per-cycle monitor for R6
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(rail_hold_low ^ prev_hold) > 1) mon_bad++;
      if (!(rail_hold_low inside {3'b111, 3'b110, 3'b100, 3'b000})) mon_bad++;
    end
    prev_hold = rail_hold_low;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en_in = 1'b1;
    prev_hold = 3'b111;
    repeat (10) @(negedge clk);
    check3("R1 reset rails", rail_hold_low, 3'b111);
    check3("R1 reset status", seq_status, 3'b000);
    check3("R2 en ignored in reset", rail_hold_low, 3'b111);

    rst_n = 1'b1;
    repeat (24) @(negedge clk);
    check3("R2 no release before N+5", rail_hold_low, 3'b111);
    @(negedge clk);
    check3("R2 release at N+5", rail_hold_low, 3'b110);

    for (int i = 0; i < NV; i++) begin
      en_in = VEC[i][11];
      repeat (int'(VEC[i][10:3])) @(negedge clk);
      check3(tag_of(i), rail_hold_low, VEC[i][2:0]);
    end

    // R3: exact first-release latency from idle
    en_in = 1'b1;
    repeat (22) @(negedge clk);
    check3("R3 before N+3", rail_hold_low, 3'b111);
    @(negedge clk);
    check3("R3 at N+3", rail_hold_low, 3'b110);
    check3("R9 status one released", seq_status, 3'b101);
    repeat (40) @(negedge clk);
    check3("R9 status all released", seq_status, 3'b111);

    en_in = 1'b0;
    repeat (3) @(negedge clk);
    check3("R9 status enable dropped", seq_status, 3'b011);

    checks++;
    if (mon_bad != 0) begin
      errors++;
      $display("FAIL R6: actual=%0d bad cycles expected=0", mon_bad);
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check3("R1 async reset rails", rail_hold_low, 3'b111);
    check3("R1 async reset status", seq_status, 3'b000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule